// File: doc/BRIEF.md
# I2C Slave Byte-Handshake Controller

This block is an I2C bus target that moves one byte at a time under control of a host processor. It samples the clock and data lines, recognises Start and Stop, collects the address byte and compares its upper seven bits with a programmable target address. When a byte ends, it raises a one-cycle interrupt. On the next low phase of SCL it holds SCL low. The clock stays held until the processor writes the control/status register.

Through that register the processor chooses whether the ninth bit of a received byte is an acknowledge, and whether the next byte is sent or received. Status flags are set by hardware and cleared when the processor writes a zero into their position. Writing a one leaves a flag unchanged. Start and Stop conditions that arrive at a misplaced time are recorded as a bus error.

Both lines are open-drain. The block only pulls a line low or releases it. The board provides the pull-ups.

Top module: `i2c_byte_slave`

## Requirements
- R1: After reset the control/status register reads 0x00, neither line is pulled and the interrupt is low.
- R2: An address byte whose bits [7:1] equal `own_addr_i` does three things: it sets Byte Complete (bit 0) and Address (bit 3), it pulses `irq_o` for one cycle, and it places the whole byte on `rx_data_o`.
- R3: After a byte completes, SCL is held low from its next low phase onward. The hold lasts until the control register is written (`reg_wr_i`=1, `reg_sel_i`=0). A write to the data register (`reg_sel_i`=1) does not release it.
- R4: On the ninth clock of a received byte the block acts on the ACK bit (bit 4) written at the release. A 1 pulls SDA low. A 0 leaves SDA released and returns the block to idle. Hardware clears bit 4 at the next byte-complete event.
- R5: An address byte with a different upper seven bits does not interrupt and does not change the register. SDA is not driven on its ninth clock.
- R6: Data bytes are received MSB first and appear on `rx_data_o`, with Byte Complete set.
- R7: If the releasing write sets Transmit (bit 2), the data register is loaded and shifted out MSB first on SDA. After the master's acknowledge bit is sampled, Byte Complete is set and that bit is stored in bit 1 (0 = ACK, 1 = NACK).
- R8: Writing 0 to a status bit position clears that bit. Writing 1 leaves it unchanged.
- R9: A Stop sets Stop Status (bit 5), and hardware never clears it. It pulses `irq_o` only when `stop_ie_i` is 1. Firmware can clear it only while Byte Complete is set.
- R10: A Start or Stop is legal only when the block is idle, or when it is a receiver at the first bit of a new byte after an ACK. At any other time it sets Bus Error (bit 7), which hardware never clears. The block then still recovers on the next Start.
- R11: Any Start clears Transmit, Last Received Bit and Byte Complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Target address matched against address bits [7:1] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control/status register, 1 selects data register |
| reg_wdata_i | input | 8 | Write data |
| ctl_rdata_o | output | 8 | Control/status register contents (bit 6 reads 0) |
| rx_data_o | output | 8 | Last byte received from the bus |
| stop_ie_i | input | 1 | Enables the interrupt on Stop |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The checker assumes that SCL cannot show a high level while the block itself pulls it low. This is what makes the clock hold last until a control write. It also assumes that the system clock is far faster than the bus, so each line change passes the synchronizer before the next one arrives.

The bench drives both lines through a wired-AND with the block's pull outputs. The master waits until the line is really high before counting a clock high phase. Every line change is spaced sixteen system cycles apart.

// File: rtl/i2c_bs_pkg.sv
package i2c_bs_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned B_BERR = 7;
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_ACK  = 4;
  localparam int unsigned B_ADDR = 3;
  localparam int unsigned B_TX   = 2;
  localparam int unsigned B_LRB  = 1;
  localparam int unsigned B_BC   = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_TX, ST_ACKO, ST_ACKI, ST_HOLD
  } bs_state_e;
endpackage

// File: rtl/i2c_bs_line_sync.sv
module i2c_bs_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      prev_o <= 1'b1;
    end else begin
      sh     <= {sh[STAGES-2:0], line_i};
      prev_o <= sh[STAGES-1];
    end
  end

  assign lvl_o = sh[STAGES-1];
endmodule

// File: rtl/i2c_bs_core.sv
module i2c_bs_core
  import i2c_bs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ctl_wr,
  input  logic              wr_ack,
  input  logic              wr_tx,
  input  logic [ADDR_W:0]   tx_data,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic [ADDR_W:0]   rx_byte_o,
  output logic              start_evt_o,
  output logic              stop_evt_o,
  output logic              berr_evt_o,
  output logic              bc_evt_o,
  output logic              addr_evt_o,
  output logic              lrb_evt_o,
  output logic              lrb_val_o
);
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CW     = $clog2(BYTE_W);

  bs_state_e         state;
  logic [CW-1:0]     bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              hold_tx, nack_flag, ack_sent, tx_req;

  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire legal     = (state == ST_IDLE) || ((state == ST_RX) && (bitcnt <= CW'(1)));
  wire [BYTE_W-1:0] nxt_byte = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  rx_byte_o <= '0;
      hold_tx <= 1'b0;  nack_flag <= 1'b0;  ack_sent <= 1'b0;  tx_req <= 1'b0;
      scl_pull_o <= 1'b0;  sda_pull_o <= 1'b0;
      start_evt_o <= 1'b0;  stop_evt_o <= 1'b0;  berr_evt_o <= 1'b0;
      bc_evt_o <= 1'b0;  addr_evt_o <= 1'b0;  lrb_evt_o <= 1'b0;  lrb_val_o <= 1'b0;
    end else begin
      start_evt_o <= 1'b0;  stop_evt_o <= 1'b0;  berr_evt_o <= 1'b0;
      bc_evt_o <= 1'b0;  addr_evt_o <= 1'b0;  lrb_evt_o <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;  bitcnt <= '0;
        sda_pull_o <= 1'b0;  scl_pull_o <= 1'b0;
        start_evt_o <= 1'b1;  berr_evt_o <= ~legal;
      end else if (stop_det) begin
        state <= ST_IDLE;  bitcnt <= '0;
        sda_pull_o <= 1'b0;  scl_pull_o <= 1'b0;
        stop_evt_o <= 1'b1;  berr_evt_o <= ~legal;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: if (scl_rise) begin
            shreg <= nxt_byte;
            if (bitcnt == CW'(BYTE_W-1)) begin
              bitcnt <= '0;
              rx_byte_o <= nxt_byte;
              if ((state == ST_ADDR) && (nxt_byte[BYTE_W-1:1] != own_addr)) begin
                state <= ST_IDLE;
              end else begin
                state <= ST_HOLD;  hold_tx <= 1'b0;
                bc_evt_o <= 1'b1;  addr_evt_o <= (state == ST_ADDR);
              end
            end else begin
              bitcnt <= bitcnt + CW'(1);
            end
          end
          ST_HOLD: begin
            scl_pull_o <= ~ctl_wr & (scl_pull_o | ~scl_s);
            if (ctl_wr) begin
              if (!hold_tx) begin
                state <= ST_ACKO;  sda_pull_o <= wr_ack;
                ack_sent <= wr_ack;  tx_req <= wr_tx;  shreg <= tx_data;
              end else if (wr_tx && !nack_flag) begin
                state <= ST_TX;  bitcnt <= '0;
                shreg <= tx_data;  sda_pull_o <= ~tx_data[BYTE_W-1];
              end else begin
                state <= ST_IDLE;  sda_pull_o <= 1'b0;
              end
            end
          end
          ST_ACKO: if (scl_fall) begin
            bitcnt <= '0;
            if (!ack_sent) begin
              state <= ST_IDLE;  sda_pull_o <= 1'b0;
            end else if (tx_req) begin
              state <= ST_TX;  sda_pull_o <= ~shreg[BYTE_W-1];
            end else begin
              state <= ST_RX;  sda_pull_o <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == CW'(BYTE_W-1)) begin
              state <= ST_ACKI;  sda_pull_o <= 1'b0;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              sda_pull_o <= ~shreg[BYTE_W-2];
              bitcnt <= bitcnt + CW'(1);
            end
          end
          ST_ACKI: if (scl_rise) begin
            nack_flag <= sda_s;  lrb_val_o <= sda_s;  lrb_evt_o <= 1'b1;
            bc_evt_o <= 1'b1;  hold_tx <= 1'b1;  state <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_bs_regs.sv
module i2c_bs_regs
  import i2c_bs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             dat_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             stop_ie,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             berr_evt,
  input  logic             bc_evt,
  input  logic             addr_evt,
  input  logic             lrb_evt,
  input  logic             lrb_val,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] txd_o,
  output logic             irq_o
);
  logic berr, stop_st, ack, addr, tx, lrb, bc;
  logic unused_wr_bit;
  assign unused_wr_bit = wdata[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      {berr, stop_st, ack, addr, tx, lrb, bc} <= '0;
      txd_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (ctl_wr) begin
        berr <= berr & wdata[B_BERR];
        if (bc) stop_st <= stop_st & wdata[B_STOP];
        ack  <= wdata[B_ACK];
        addr <= addr & wdata[B_ADDR];
        tx   <= wdata[B_TX];
        lrb  <= lrb & wdata[B_LRB];
        bc   <= bc & wdata[B_BC];
      end
      if (dat_wr) txd_o <= wdata;
      if (start_evt) begin
        tx <= 1'b0;  lrb <= 1'b0;  bc <= 1'b0;
      end
      if (stop_evt) stop_st <= 1'b1;
      if (berr_evt) berr <= 1'b1;
      if (bc_evt) begin
        bc <= 1'b1;  ack <= 1'b0;
      end
      if (addr_evt) addr <= 1'b1;
      if (lrb_evt) lrb <= lrb_val;
      irq_o <= bc_evt | (stop_evt & stop_ie);
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[B_BERR] = berr;
    ctl_o[B_STOP] = stop_st;
    ctl_o[B_ACK]  = ack;
    ctl_o[B_ADDR] = addr;
    ctl_o[B_TX]   = tx;
    ctl_o[B_LRB]  = lrb;
    ctl_o[B_BC]   = bc;
  end
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
  import i2c_bs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W:0]   reg_wdata_i,
  output logic [ADDR_W:0]   ctl_rdata_o,
  output logic [ADDR_W:0]   rx_data_o,
  input  logic              stop_ie_i,
  output logic              irq_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] lines, lvl, prev;
  logic [ADDR_W:0]   txd;
  logic start_evt, stop_evt, berr_evt, bc_evt, addr_evt, lrb_evt, lrb_val;
  logic ctl_wr, dat_wr;

  assign lines  = {sda_i, scl_i};
  assign ctl_wr = reg_wr_i & ~reg_sel_i;
  assign dat_wr = reg_wr_i & reg_sel_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_bs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .line_i(lines[g]), .lvl_o(lvl[g]), .prev_o(prev[g])
    );
  end

  i2c_bs_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst),
    .scl_s(lvl[0]), .scl_p(prev[0]), .sda_s(lvl[1]), .sda_p(prev[1]),
    .own_addr(own_addr_i), .ctl_wr(ctl_wr),
    .wr_ack(reg_wdata_i[B_ACK]), .wr_tx(reg_wdata_i[B_TX]), .tx_data(txd),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .rx_byte_o(rx_data_o),
    .start_evt_o(start_evt), .stop_evt_o(stop_evt), .berr_evt_o(berr_evt),
    .bc_evt_o(bc_evt), .addr_evt_o(addr_evt), .lrb_evt_o(lrb_evt), .lrb_val_o(lrb_val)
  );

  i2c_bs_regs u_regs (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .dat_wr(dat_wr), .wdata(reg_wdata_i),
    .stop_ie(stop_ie_i), .start_evt(start_evt), .stop_evt(stop_evt),
    .berr_evt(berr_evt), .bc_evt(bc_evt), .addr_evt(addr_evt),
    .lrb_evt(lrb_evt), .lrb_val(lrb_val),
    .ctl_o(ctl_rdata_o), .txd_o(txd), .irq_o(irq_o)
  );
endmodule

// File: rtl/i2c_byte_slave_chk.sv
module i2c_byte_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] wdata,
  input logic [7:0] ctl,
  input logic       scl_pull,
  input logic       start_evt,
  input logic       stop_evt
);
  a_r3_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (scl_pull && !ctl_wr) |=> scl_pull);

  a_r3_write_releases: assert property (@(posedge clk) disable iff (rst)
    (scl_pull && ctl_wr) |=> !scl_pull);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (ctl[2:0] == 3'b000));

  a_r9_stop_sets_status: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> ctl[5]);

  a_r10_berr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctl[7] && !(ctl_wr && !wdata[7])) |=> ctl[7]);

  a_r9_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctl[5] && !ctl_wr) |=> ctl[5]);
endmodule

bind i2c_byte_slave i2c_byte_slave_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(reg_wdata_i), .ctl(ctl_rdata_o),
  .scl_pull(scl_pull_o), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/test_i2c_byte_slave.sv
module test_i2c_byte_slave;
  localparam int Q = 16;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  logic reg_wr = 1'b0, reg_sel = 1'b0, stop_ie = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl, rxd;
  logic irq;
  int errors = 0, checks = 0, irq_cnt = 0;
  bit done = 1'b0;

  wire scl_line = scl_m & ~scl_pull;
  wire sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  i2c_byte_slave i_i2c_byte_slave (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(OWN),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(wdata),
    .ctl_rdata_o(ctl), .rx_data_o(rxd), .stop_ie_i(stop_ie), .irq_o(irq)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fw_wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel; wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    wt(2);
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wt(Q);
    scl_m = 1'b1;
    while (!scl_line) wt(1);
    wt(Q);
    r = sda_line;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_byte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      m_bit(d[i], b);
      r[i] = b;
    end
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl, 8'h00);
    chk("R1 pulls", {scl_pull, sda_pull}, 2'b00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_write_xfer;
    logic [7:0] r; logic b; int ic;
    stop_ie = 1'b0;
    ic = irq_cnt;
    m_start;
    m_byte({OWN, 1'b0}, r);
    chk("R2 ctl after address", ctl, 8'h09);
    chk("R2 rx_data", rxd, {OWN, 1'b0});
    chk("R2 irq count", irq_cnt - ic, 1);
    scl_m = 1'b1; wt(40);
    chk("R3 scl held", scl_line, 1'b0);
    fw_wr(1'b1, 8'h55);
    wt(10);
    chk("R3 data write keeps hold", scl_line, 1'b0);
    fw_wr(1'b0, 8'h10);
    chk("R8 write clears bc/addr", ctl, 8'h10);
    m_bit(1'b1, b);
    chk("R4 ack driven", b, 1'b0);
    m_byte(8'hC3, r);
    chk("R6 rx data", rxd, 8'hC3);
    chk("R4 ack cleared at bc", ctl, 8'h01);
    fw_wr(1'b0, 8'h00);
    m_bit(1'b1, b);
    chk("R4 nack leaves sda", b, 1'b1);
    ic = irq_cnt;
    m_stop;
    chk("R9 stop status no berr R10", ctl, 8'h20);
    chk("R9 no irq when disabled", irq_cnt - ic, 0);
    fw_wr(1'b0, 8'h00);
    chk("R9 stop not cleared without bc", ctl, 8'h20);
  endtask

  task automatic t_read_xfer;
    logic [7:0] r; logic b; int ic;
    stop_ie = 1'b1;
    m_start;
    m_byte({OWN, 1'b1}, r);
    chk("R2 read address", ctl, 8'h29);
    fw_wr(1'b1, 8'hA6);
    fw_wr(1'b0, 8'h14);
    chk("R9 stop cleared with bc", ctl, 8'h14);
    m_bit(1'b1, b);
    chk("R4 address ack", b, 1'b0);
    m_byte(8'hFF, r);
    chk("R7 tx byte 1", r, 8'hA6);
    m_bit(1'b0, b);
    chk("R7 lrb ack", ctl, 8'h05);
    fw_wr(1'b1, 8'h3C);
    fw_wr(1'b0, 8'h04);
    m_byte(8'hFF, r);
    chk("R7 tx byte 2", r, 8'h3C);
    m_bit(1'b1, b);
    chk("R7 lrb nack", ctl, 8'h07);
    fw_wr(1'b0, 8'h07);
    chk("R8 write ones keeps", ctl, 8'h07);
    ic = irq_cnt;
    m_stop;
    chk("R9 stop irq enabled", irq_cnt - ic, 1);
    chk("R9 stop after read", ctl, 8'h27);
    fw_wr(1'b0, 8'h26);
    chk("R8 bc cleared only", ctl, 8'h26);
  endtask

  task automatic t_start_and_mismatch;
    logic [7:0] r; logic b; int ic;
    m_start;
    chk("R11 start clears tx lrb bc", ctl, 8'h20);
    ic = irq_cnt;
    m_byte({7'h11, 1'b0}, r);
    chk("R5 no status change", ctl, 8'h20);
    chk("R5 no irq", irq_cnt - ic, 0);
    m_bit(1'b1, b);
    chk("R5 no ack", b, 1'b1);
    m_stop;
    chk("R10 legal stop in idle", ctl[7], 1'b0);
  endtask

  task automatic t_bus_error;
    logic [7:0] r; logic b;
    stop_ie = 1'b0;
    m_start;
    m_byte({OWN, 1'b0}, r);
    fw_wr(1'b0, 8'h10);
    m_bit(1'b1, b);
    m_bit(1'b0, b);
    m_bit(1'b1, b);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
    chk("R10 misplaced stop", ctl, 8'hB0);
    fw_wr(1'b0, 8'h80);
    chk("R10 berr kept on write 1", ctl, 8'hA0);
    fw_wr(1'b0, 8'h00);
    chk("R8 berr cleared by 0", ctl, 8'h20);
    m_start;
    m_byte({OWN, 1'b0}, r);
    chk("R10 recovers on start", ctl, 8'h29);
    fw_wr(1'b0, 8'h00);
    m_bit(1'b1, b);
    m_stop;
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset;
    t_write_xfer;
    t_read_xfer;
    t_start_and_mismatch;
    t_bus_error;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule